// File: doc/BRIEF.md
# Direct-Access Command Decoder

This block watches a downlink bit stream that has already been demodulated into one strobed bit per symbol. It picks out the command that asks the tag to read one memory block over and over. A frame starts with a two-bit opcode. The first opcode bit is 1, and the second bit names the page. In the plain form, a zero separator bit and a three-bit block number follow the opcode. When the password-enable flag is set, a 32-bit password comes between the opcode and the separator. That password is compared with the stored password word.

A valid command raises a one-clock block-read start pulse and latches the effective read address. The address is remapped for page 1: block 0 of page 1 points at the configuration block of page 0. Blocks above 2 of page 1 keep their number but raise a force-zero flag, so the read path returns all-zero data. A password mismatch, a bad separator, or a frame of the wrong length raises a one-clock pulse that sends the tag back to cyclic regular reading. A frame whose first bit is 0 belongs to some other command and is ignored.

Top module: `da_cmd_decoder`

## Requirements
- R1: While reset is held, and after it is released, page_o, blk_addr_o, force_zero_o, blk_rd_start_o and rd_fallback_o are all 0.
- R2: With pwd_en_i low, the frame 1, P, 0, A2, A1, A0 (address MSB first) raises blk_rd_start_o for one clock, starting with the clock edge that samples A0.
- R3: With pwd_en_i high at the frame's first bit, the block expects 1, P, a 32-bit password MSB first, 0, then the address MSB first. When the password equals pwd_ref_i, the start pulse follows the last address bit. A plain 6-bit frame ends short in this mode.
- R4: When the received password differs from pwd_ref_i, rd_fallback_o pulses for one clock after the last address bit, no start pulse occurs, and page_o, blk_addr_o and force_zero_o keep their values.
- R5: A separator bit of 1 produces a fallback pulse in place of a start pulse.
- R6: A frame that ends (frame_end_i) after at least one bit, beginning with 1, but before the full length, produces a fallback pulse one clock after the frame end.
- R7: Bits received after a complete command make the frame overlong. The start pulse already issued stands, and a fallback pulse follows the frame end.
- R8: A frame whose first bit is 0 produces no pulse and leaves all outputs unchanged.
- R9: Page 1, block 0 sets page_o=0, blk_addr_o=0, force_zero_o=0.
- R10: Page 1, blocks 1 and 2 set page_o=1, the same block number, force_zero_o=0. Page 0 passes every block through with force_zero_o=0.
- R11: Page 1, blocks 3 to 7 set page_o=1, the same block number, force_zero_o=1.
- R12: Both pulses last exactly one clock and never occur together. page_o, blk_addr_o and force_zero_o change only in the clock of a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received bit value |
| bit_valid_i | input | 1 | Strobe: bit_i is valid this clock |
| frame_end_i | input | 1 | Downlink frame has ended (a bit in the same clock counts first) |
| pwd_en_i | input | 1 | Password form required |
| pwd_ref_i | input | PW_W | Stored password word |
| page_o | output | 1 | Effective page of the selected block |
| blk_addr_o | output | ADDR_W | Effective block number |
| force_zero_o | output | 1 | Read data must be returned as zeros |
| blk_rd_start_o | output | 1 | One-clock pulse: enter block-read mode |
| rd_fallback_o | output | 1 | One-clock pulse: return to regular-read mode |

## Verification
The bench builds the block with its default parameters, PW_W=32 and ADDR_W=3. With these values the password frame is 38 bits long, and all eight block numbers of both pages fit in a short run. Every remap case is therefore covered exhaustively, not just sampled. A fixed non-trivial password word lets the bench test a single-bit mismatch as well as a correct match.

// File: rtl/da_cmd_pkg.sv
package da_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_DONE = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/da_shift_in.sv
module da_shift_in #(
  parameter int unsigned W  = 38,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          clear_i,
  input  logic          bit_i,
  output logic [W-1:0]  next_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o
);
  logic [W-1:0]  vec_q;
  logic [CW-1:0] cnt_q;

  assign next_o     = {vec_q[W-2:0], bit_i};
  assign cnt_next_o = cnt_q + CW'(1);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      vec_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      vec_q <= next_o;
      cnt_q <= cnt_next_o;
    end
  end

  // R7: the counter never runs past one full password frame
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W))
    else $error("bit counter beyond frame length");
endmodule

// File: rtl/da_pw_match.sv
module da_pw_match #(
  parameter int unsigned PW_W = 32
) (
  input  logic            check_i,
  input  logic [PW_W-1:0] rx_pw_i,
  input  logic [PW_W-1:0] ref_pw_i,
  output logic            ok_o
);
  assign ok_o = !check_i || (rx_pw_i == ref_pw_i);
endmodule

// File: rtl/da_addr_map.sv
module da_addr_map #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned CFG_BLK   = 0,
  parameter int unsigned LIVE_LAST = 2
) (
  input  logic              page_i,
  input  logic [ADDR_W-1:0] blk_i,
  output logic              page_o,
  output logic [ADDR_W-1:0] blk_o,
  output logic              force_zero_o
);
  always_comb begin
    page_o       = page_i;
    blk_o        = blk_i;
    force_zero_o = 1'b0;
    if (page_i) begin
      if (blk_i == ADDR_W'(CFG_BLK)) begin
        page_o = 1'b0;              // config block lives on page 0
      end else if (blk_i > ADDR_W'(LIVE_LAST)) begin
        force_zero_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (force_zero_o) begin
      p_zero_only_high_p1_r11: assert (page_o && (blk_i > ADDR_W'(LIVE_LAST)))
        else $error("force-zero outside page-1 upper blocks");
    end
  end
endmodule

// File: rtl/da_cmd_decoder.sv
module da_cmd_decoder
  import da_cmd_pkg::*;
#(
  parameter int unsigned PW_W   = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              frame_end_i,
  input  logic              pwd_en_i,
  input  logic [PW_W-1:0]   pwd_ref_i,
  output logic              page_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic              force_zero_o,
  output logic              blk_rd_start_o,
  output logic              rd_fallback_o
);
  localparam int unsigned OP_W    = 2;
  localparam int unsigned LEN_PLN = OP_W + 1 + ADDR_W;
  localparam int unsigned LEN_PW  = LEN_PLN + PW_W;
  localparam int unsigned CW      = $clog2(LEN_PW + 1);

  rx_state_e state_q, state_d;
  logic pw_mode_q, page_q, long_q, long_d;
  logic start_d, fb_d, clr, shift, complete, cmd_ok, pw_ok;
  logic pw_mode_eff;
  logic [CW-1:0]     need, cnt, cnt_next;
  logic [LEN_PW-1:0] nv;
  logic              map_page, map_fz;
  logic [ADDR_W-1:0] map_blk;

  assign shift       = bit_valid_i && (state_q == ST_IDLE || state_q == ST_RX);
  assign pw_mode_eff = (state_q == ST_IDLE) ? pwd_en_i : pw_mode_q;
  assign need        = pw_mode_eff ? CW'(LEN_PW) : CW'(LEN_PLN);
  assign complete    = shift && (state_q == ST_RX) && (cnt_next == need);

  da_shift_in #(.W(LEN_PW), .CW(CW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .clear_i    (clr),
    .bit_i      (bit_i),
    .next_o     (nv),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  da_pw_match #(.PW_W(PW_W)) u_pw (
    .check_i  (pw_mode_q),
    .rx_pw_i  (nv[ADDR_W+1 +: PW_W]),
    .ref_pw_i (pwd_ref_i),
    .ok_o     (pw_ok)
  );

  assign cmd_ok = pw_ok && !nv[ADDR_W];

  da_addr_map #(.ADDR_W(ADDR_W), .CFG_BLK(0), .LIVE_LAST(2)) u_map (
    .page_i       (page_q),
    .blk_i        (nv[ADDR_W-1:0]),
    .page_o       (map_page),
    .blk_o        (map_blk),
    .force_zero_o (map_fz)
  );

  always_comb begin
    state_d = state_q;
    long_d  = long_q;
    start_d = 1'b0;
    fb_d    = 1'b0;
    clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        long_d = 1'b0;
        if (bit_valid_i) state_d = bit_i ? ST_RX : ST_SKIP;
        if (frame_end_i) begin
          state_d = ST_IDLE;
          clr     = 1'b1;
          fb_d    = bit_valid_i && bit_i;   // one-bit frame is short
        end
      end
      ST_RX: begin
        if (complete) begin
          start_d = cmd_ok;
          fb_d    = !cmd_ok;
          state_d = ST_DONE;
        end
        if (frame_end_i) begin
          clr     = 1'b1;
          state_d = ST_IDLE;
          if (!complete) fb_d = 1'b1;
        end
      end
      ST_DONE: begin
        if (bit_valid_i) long_d = 1'b1;
        if (frame_end_i) begin
          clr     = 1'b1;
          state_d = ST_IDLE;
          fb_d    = long_q || bit_valid_i;
          long_d  = 1'b0;
        end
      end
      ST_SKIP: begin
        if (frame_end_i) begin
          clr     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      pw_mode_q      <= 1'b0;
      page_q         <= 1'b0;
      long_q         <= 1'b0;
      blk_rd_start_o <= 1'b0;
      rd_fallback_o  <= 1'b0;
      page_o         <= 1'b0;
      blk_addr_o     <= '0;
      force_zero_o   <= 1'b0;
    end else begin
      state_q        <= state_d;
      long_q         <= long_d;
      blk_rd_start_o <= start_d;
      rd_fallback_o  <= fb_d;
      if (state_q == ST_IDLE && bit_valid_i) pw_mode_q <= pwd_en_i;
      if (state_q == ST_RX && bit_valid_i && cnt == CW'(1)) page_q <= bit_i;
      if (start_d) begin
        page_o       <= map_page;
        blk_addr_o   <= map_blk;
        force_zero_o <= map_fz;
      end
    end
  end

  p_pulse_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(blk_rd_start_o && rd_fallback_o))
    else $error("start and fallback together");

  p_start_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_rd_start_o |=> !blk_rd_start_o)
    else $error("start pulse longer than one clock");

  p_fb_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fallback_o |=> !rd_fallback_o)
    else $error("fallback pulse longer than one clock");

  p_start_after_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_rd_start_o) |-> $past(bit_valid_i))
    else $error("start not caused by an accepted bit");

  p_fb_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_fallback_o) |-> $past(bit_valid_i || frame_end_i))
    else $error("fallback without bit or frame end");

  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_rd_start_o |-> $stable({page_o, blk_addr_o, force_zero_o}))
    else $error("address outputs moved without a start pulse");
endmodule

// File: tb/tb_da_cmd_decoder.sv
module tb_da_cmd_decoder;
  localparam int unsigned PW_W   = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [PW_W-1:0] PW = 32'hA5C3_1F0E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_v = 1'b0, bit_val = 1'b0, fend = 1'b0, pen = 1'b0;
  logic page, fz, start, fb;
  logic [ADDR_W-1:0] addr;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  da_cmd_decoder #(.PW_W(PW_W), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .bit_valid_i(bit_val),
    .frame_end_i(fend), .pwd_en_i(pen), .pwd_ref_i(PW),
    .page_o(page), .blk_addr_o(addr), .force_zero_o(fz),
    .blk_rd_start_o(start), .rd_fallback_o(fb)
  );

  typedef struct {
    bit             is_fb;
    bit             pg;
    logic [ADDR_W-1:0] ad;
    bit             z;
    string          tag;
  } exp_t;

  exp_t q[$];
  exp_t got;
  bit cur_pg = 1'b0, cur_z = 1'b0;
  logic [ADDR_W-1:0] cur_ad = '0;

  task automatic push_start(input bit pg_in, input logic [ADDR_W-1:0] a, input string tag);
    exp_t e;
    if (pg_in && a == 0)      begin cur_pg = 1'b0; cur_z = 1'b0; end
    else if (pg_in && a <= 2) begin cur_pg = 1'b1; cur_z = 1'b0; end
    else if (pg_in)           begin cur_pg = 1'b1; cur_z = 1'b1; end
    else                      begin cur_pg = 1'b0; cur_z = 1'b0; end
    cur_ad = a;
    e.is_fb = 1'b0; e.pg = cur_pg; e.ad = cur_ad; e.z = cur_z; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_fb(input string tag);
    exp_t e;
    e.is_fb = 1'b1; e.pg = cur_pg; e.ad = cur_ad; e.z = cur_z; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_val = 1'b1; bit_v = v[i];
    end
    @(negedge clk); bit_val = 1'b0; bit_v = 1'b0;
    @(negedge clk); fend = 1'b1;
    @(negedge clk); fend = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] pln(input bit pg_in, input bit sep, input logic [ADDR_W-1:0] a);
    return 64'({1'b1, pg_in, sep, a});
  endfunction

  function automatic logic [63:0] pwf(input bit pg_in, input logic [PW_W-1:0] p, input bit sep,
                                      input logic [ADDR_W-1:0] a);
    return 64'({1'b1, pg_in, p, sep, a});
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && (start || fb)) begin
      n_vec++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected pulse (R8/R12): start=%0b fb=%0b expected none", start, fb);
      end else begin
        got = q.pop_front();
        if (fb !== got.is_fb || start !== !got.is_fb || page !== got.pg ||
            addr !== got.ad || fz !== got.z) begin
          n_bad++;
          $display("FAIL %s: got start=%0b fb=%0b page=%0b addr=%0d fz=%0b expected start=%0b fb=%0b page=%0b addr=%0d fz=%0b",
                   got.tag, start, fb, page, addr, fz, !got.is_fb, got.is_fb, got.pg, got.ad, got.z);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;  // R1 reset state
    if ({page, addr, fz, start, fb} !== '0) begin
      n_bad++;
      $display("FAIL R1: got %b expected 0", {page, addr, fz, start, fb});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R10: page 0, all blocks
    for (int a = 0; a < 8; a++) begin
      push_start(1'b0, ADDR_W'(a), "R2/R10");
      send(pln(1'b0, 1'b0, ADDR_W'(a)), 6);
    end
    // R9, R10, R11: page 1 remap, all blocks
    for (int a = 0; a < 8; a++) begin
      push_start(1'b1, ADDR_W'(a), a == 0 ? "R9" : (a <= 2 ? "R10" : "R11"));
      send(pln(1'b1, 1'b0, ADDR_W'(a)), 6);
    end
    // R5: bad separator
    push_fb("R5");
    send(pln(1'b0, 1'b1, 3'd3), 6);
    // R6: short frame
    push_fb("R6");
    send(64'b1001, 4);
    // R8: foreign command, first bit 0
    send(64'b010101, 6);
    // R7: overlong after a valid command
    push_start(1'b0, 3'd6, "R7");
    push_fb("R7");
    send(64'b1001101, 7);
    // R3: password form
    pen = 1'b1;
    push_start(1'b1, 3'd2, "R3");
    send(pwf(1'b1, PW, 1'b0, 3'd2), 38);
    push_start(1'b0, 3'd5, "R3");
    send(pwf(1'b0, PW, 1'b0, 3'd5), 38);
    // R4: password off by one bit, outputs must hold
    push_fb("R4");
    send(pwf(1'b1, PW ^ 32'h0000_0100, 1'b0, 3'd4), 38);
    // R5 in password form
    push_fb("R5");
    send(pwf(1'b0, PW, 1'b1, 3'd1), 38);
    // R3: plain frame under password mode is short
    push_fb("R3");
    send(pln(1'b0, 1'b0, 3'd1), 6);
    // R8 in password mode
    send(64'b00, 2);
    pen = 1'b0;
    // R12: back-to-back valid command after the above
    push_start(1'b1, 3'd7, "R12");
    send(pln(1'b1, 1'b0, 3'd7), 6);

    repeat (5) @(negedge clk);
    n_vec++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R12: got %0d pending pulses expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule